// File: doc/BRIEF.md
# Dual-Edge Interrupting GPIO Bank

This block is one bank of general-purpose pins behind a small synchronous register bus. Software chooses per pin whether it drives (an output enable and output level come out on separate vectors, ready for a pad's tristate buffer) or listens. Incoming pin levels pass through a multi-flop synchroniser before anything inside looks at them. A read of the data register gives the driven level for output pins and the synchronised level for input pins.

Every synchronised pin is watched for changes. Changes are sorted into two kinds of event. The per-pin polarity bit decides whether a rising or a falling transition is the "assert" kind, and the opposite transition is then the "deassert" kind. Each kind latches into its own sticky status register and has its own interrupt line. The interrupt line is the OR of status bits gated by a shared per-pin enable. Status bits are cleared by writing ones. Their layout is shifted by one: bit 0 is never used, so one status word serves only the low 31 pins.

The intended software sequence is to clear a pin's pending assert and deassert status first and then set its enable bit. Without that step, an edge that was latched earlier raises the interrupt at once.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset every register reads zero, `pin_oe` and `pin_out` are all zero, and both interrupt lines are low.
- R2: Writing the direction register (word address 0) takes effect on the next clock: a bit of 1 drives `pin_oe` high for that pin, a bit of 0 releases it. `pin_out` always carries the output-level register (word address 1).
- R3: A read of word address 2 returns, per pin, the output-level register bit when the direction bit is 1, and otherwise the input level after the synchroniser. An input change is visible to a read issued four or more cycles later.
- R4: With the polarity bit of a pin at 1 (word address 4), a rising input sets that pin's bit in the assert status (word address 5) and a falling input sets its bit in the deassert status (word address 6). No other bit changes.
- R5: With the polarity bit at 0 the roles swap: a falling input sets the assert status and a rising input sets the deassert status.
- R6: Status bit 0 always reads 0. Pin n (0 to 30) sits at status bit n+1. Pin 31 has no status slot and never sets any status bit.
- R7: Writing a status register clears exactly the bits written as 1. Bits written as 0 keep their value.
- R8: When a new event for a bit and a write-one-to-clear of that same bit happen in the same cycle, the bit ends up set.
- R9: Status latches events even when the pin's enable bit (word address 3, bit n for pin n) is 0. `irq_assert` is high exactly when some assert-status bit n+1 and enable bit n are both 1, and `irq_deassert` does the same with the deassert status.
- R10: Reads return data on `bus_rdata` in the cycle after the request. A write to word address 2 or 7 changes nothing, and a read of word address 7 returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| pin_in | input | 32 | Asynchronous pin levels from the pads |
| pin_out | output | 32 | Output level toward the pads |
| pin_oe | output | 32 | Per-pin output enable toward the pads |
| irq_assert | output | 1 | Interrupt from enabled assert-status bits |
| irq_deassert | output | 1 | Interrupt from enabled deassert-status bits |

## Verification
The embedded properties check several rules on every cycle. Assert and deassert events never coincide on one pin. A status bit only rises on an event. An event always beats a same-cycle clear, and a clear without a competing event always empties its bits. The output enable follows a direction write. Writes to the data word leave the register file alone. Status reads never return bit 0 set, and an interrupt never appears without some enable bit. The remaining behaviours need the bench's scenarios. These are the exact bit position each pin lands on for both polarities, the latency through the synchroniser, the mixed readback of driven and sampled levels, and the silence of the pin without a status slot.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

   localparam int unsigned REG_ADDR_W = 3;

   typedef enum logic [REG_ADDR_W-1:0] {
      RS_DIR    = 3'd0,
      RS_DOUT   = 3'd1,
      RS_DATA   = 3'd2,
      RS_IEN    = 3'd3,
      RS_POL    = 3'd4,
      RS_STAT_A = 3'd5,
      RS_STAT_D = 3'd6,
      RS_NONE   = 3'd7
   } reg_sel_e;

endpackage

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_i};
      end
   end

   assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_edge_classify.sv
module gpio_edge_classify #(
   parameter int unsigned WIDTH = 31
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] level_i,
   input  logic [WIDTH-1:0] pol_i,
   output logic [WIDTH-1:0] assert_ev_o,
   output logic [WIDTH-1:0] deassert_ev_o
);

   logic [WIDTH-1:0] prev_q;
   logic [WIDTH-1:0] rise;
   logic [WIDTH-1:0] fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
      end else begin
         prev_q <= level_i;
      end
   end

   always_comb begin
      rise          = level_i & ~prev_q;
      fall          = ~level_i & prev_q;
      assert_ev_o   = (rise & pol_i) | (fall & ~pol_i);
      deassert_ev_o = (fall & pol_i) | (rise & ~pol_i);
   end

   AST_EDGE_KINDS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (assert_ev_o & deassert_ev_o) == '0); // R4

   AST_EVENT_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (|(assert_ev_o | deassert_ev_o)) |=> (prev_q != $past(prev_q))); // R5

endmodule

// File: rtl/gpio_edge_status.sv
module gpio_edge_status #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned STAT_PINS = 31
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [STAT_PINS-1:0] ev_i,
   input  logic [STAT_PINS-1:0] en_i,
   input  logic [DATA_W-1:0]    clr_i,
   output logic [DATA_W-1:0]    stat_o,
   output logic                 irq_o
);

   function automatic logic [DATA_W-1:0] live_mask();
      logic [DATA_W-1:0] m;
      m = '0;
      for (int i = 1; i <= int'(STAT_PINS); i++) begin
         m[i] = 1'b1;
      end
      return m;
   endfunction

   localparam logic [DATA_W-1:0] LIVE = live_mask();

   logic [DATA_W-1:0] stat_q;
   logic [DATA_W-1:0] ev_full;
   logic [DATA_W-1:0] en_full;

   generate
      if (STAT_PINS + 1 > DATA_W) begin : g_bad_width
         $error("gpio_edge_status: STAT_PINS must leave bit 0 free");
      end
   endgenerate

   always_comb begin
      ev_full = '0;
      en_full = '0;
      ev_full[STAT_PINS:1] = ev_i;
      en_full[STAT_PINS:1] = en_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
      end else begin
         stat_q <= ((stat_q & ~clr_i) | ev_full) & LIVE;
      end
   end

   assign stat_o = stat_q;
   assign irq_o  = |(stat_q & en_full);

   AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (|ev_i) |=> ((stat_q[STAT_PINS:1] & $past(ev_i)) == $past(ev_i))); // R8

   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (|(clr_i[STAT_PINS:1] & ~ev_i)) |=>
      ((stat_q[STAT_PINS:1] & $past(clr_i[STAT_PINS:1] & ~ev_i)) == '0)); // R7

   AST_SET_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_q[STAT_PINS:1] & ~$past(stat_q[STAT_PINS:1]) & ~$past(ev_i)) == '0)); // R4

endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
   import gpio_edge_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 32,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_sel,
   input  logic                  bus_wr,
   input  logic [REG_ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0]     bus_wdata,
   output logic [DATA_W-1:0]     bus_rdata,
   input  logic [NUM_PINS-1:0]   pin_in,
   output logic [NUM_PINS-1:0]   pin_out,
   output logic [NUM_PINS-1:0]   pin_oe,
   output logic                  irq_assert,
   output logic                  irq_deassert
);

   localparam int unsigned STAT_PINS = (NUM_PINS < DATA_W - 1) ? NUM_PINS : DATA_W - 1;

   generate
      if (NUM_PINS < 1 || NUM_PINS > DATA_W) begin : g_bad_pins
         $error("gpio_edge_bank: NUM_PINS must be 1..DATA_W");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("gpio_edge_bank: DATA_W must be at least 2");
      end
   endgenerate

   reg_sel_e            sel_e;
   logic                wr_en;
   logic                rd_en;
   logic [NUM_PINS-1:0] dir_q;
   logic [NUM_PINS-1:0] dout_q;
   logic [NUM_PINS-1:0] ien_q;
   logic [NUM_PINS-1:0] pol_q;
   logic [NUM_PINS-1:0] sync_lvl;
   logic [STAT_PINS-1:0] ev_a;
   logic [STAT_PINS-1:0] ev_d;
   logic [DATA_W-1:0]   clr_a;
   logic [DATA_W-1:0]   clr_d;
   logic [DATA_W-1:0]   stat_a;
   logic [DATA_W-1:0]   stat_d;
   logic [DATA_W-1:0]   rd_mux;
   logic [NUM_PINS-1:0] wpins;

   assign sel_e = reg_sel_e'(bus_addr);
   assign wr_en = bus_sel & bus_wr;
   assign rd_en = bus_sel & ~bus_wr;
   assign wpins = bus_wdata[NUM_PINS-1:0];

   // Control registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '0;
         dout_q <= '0;
         ien_q  <= '0;
         pol_q  <= '0;
      end else if (wr_en) begin
         case (sel_e)
            RS_DIR:  dir_q  <= wpins;
            RS_DOUT: dout_q <= wpins;
            RS_IEN:  ien_q  <= wpins;
            RS_POL:  pol_q  <= wpins;
            default: ;
         endcase
      end
   end

   assign pin_oe  = dir_q;
   assign pin_out = dout_q;

   gpio_edge_sync #(
      .WIDTH  (NUM_PINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (pin_in),
      .sync_o  (sync_lvl)
   );

   gpio_edge_classify #(
      .WIDTH (STAT_PINS)
   ) u_classify (
      .clk           (clk),
      .rst_n         (rst_n),
      .level_i       (sync_lvl[STAT_PINS-1:0]),
      .pol_i         (pol_q[STAT_PINS-1:0]),
      .assert_ev_o   (ev_a),
      .deassert_ev_o (ev_d)
   );

   assign clr_a = (wr_en && sel_e == RS_STAT_A) ? bus_wdata : '0;
   assign clr_d = (wr_en && sel_e == RS_STAT_D) ? bus_wdata : '0;

   gpio_edge_status #(
      .DATA_W    (DATA_W),
      .STAT_PINS (STAT_PINS)
   ) u_stat_assert (
      .clk    (clk),
      .rst_n  (rst_n),
      .ev_i   (ev_a),
      .en_i   (ien_q[STAT_PINS-1:0]),
      .clr_i  (clr_a),
      .stat_o (stat_a),
      .irq_o  (irq_assert)
   );

   gpio_edge_status #(
      .DATA_W    (DATA_W),
      .STAT_PINS (STAT_PINS)
   ) u_stat_deassert (
      .clk    (clk),
      .rst_n  (rst_n),
      .ev_i   (ev_d),
      .en_i   (ien_q[STAT_PINS-1:0]),
      .clr_i  (clr_d),
      .stat_o (stat_d),
      .irq_o  (irq_deassert)
   );

   // Read path
   always_comb begin
      rd_mux = '0;
      case (sel_e)
         RS_DIR:    rd_mux[NUM_PINS-1:0] = dir_q;
         RS_DOUT:   rd_mux[NUM_PINS-1:0] = dout_q;
         RS_DATA:   rd_mux[NUM_PINS-1:0] = (dout_q & dir_q) | (sync_lvl & ~dir_q);
         RS_IEN:    rd_mux[NUM_PINS-1:0] = ien_q;
         RS_POL:    rd_mux[NUM_PINS-1:0] = pol_q;
         RS_STAT_A: rd_mux = stat_a;
         RS_STAT_D: rd_mux = stat_d;
         default:   rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (rd_en) begin
         bus_rdata <= rd_mux;
      end
   end

   AST_OE_TRACKS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel_e == RS_DIR) |=> (pin_oe == $past(wpins))); // R2

   AST_DATA_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (sel_e == RS_DATA || sel_e == RS_NONE)) |=>
      ($stable(dir_q) && $stable(dout_q) && $stable(ien_q) && $stable(pol_q))); // R10

   AST_STAT_READ_BIT0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (sel_e == RS_STAT_A || sel_e == RS_STAT_D)) |=> (bus_rdata[0] == 1'b0)); // R6

   AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_assert || irq_deassert) |-> (|ien_q)); // R9

endmodule

// File: tb/gpio_edge_bank_test.sv
module gpio_edge_bank_test;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pin_in = '0;
   logic [31:0] pin_out;
   logic [31:0] pin_oe;
   logic        irq_assert;
   logic        irq_deassert;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_edge_bank uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_sel      (bus_sel),
      .bus_wr       (bus_wr),
      .bus_addr     (bus_addr),
      .bus_wdata    (bus_wdata),
      .bus_rdata    (bus_rdata),
      .pin_in       (pin_in),
      .pin_out      (pin_out),
      .pin_oe       (pin_oe),
      .irq_assert   (irq_assert),
      .irq_deassert (irq_deassert)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_sel = 1'b0;
      d = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_all();
      wr(3'd5, 32'hFFFF_FFFF);
      wr(3'd6, 32'hFFFF_FFFF);
   endtask

   initial begin
      #(CLK_PERIOD * WATCHDOG);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      logic [31:0] va;
      logic [31:0] vd;
      logic [31:0] dirv;
      logic [31:0] doutv;
      logic [31:0] pinv;

      idle(3);
      rst_n = 1'b1;
      idle(2);

      // R1: reset values
      check("R1 pin_oe", pin_oe, 32'h0);
      check("R1 pin_out", pin_out, 32'h0);
      check("R1 irqs", {30'h0, irq_assert, irq_deassert}, 32'h0);
      for (int a = 0; a < 8; a++) begin
         if (a != 2) begin
            rd(a[2:0], v);
            check($sformatf("R1 reg %0d", a), v, 32'h0);
         end
      end

      // R2 / R3: direction and mixed readback, several patterns
      for (int p = 0; p < 4; p++) begin
         dirv  = (p == 0) ? 32'h0000_FFFF : (p == 1) ? 32'hFFFF_0000 :
                 (p == 2) ? 32'hAAAA_5555 : 32'h0;
         doutv = 32'hA5A5_A5A5 ^ (32'h1111_1111 * p);
         pinv  = 32'h3C3C_F0F0 + (32'h0101_0101 * p);
         wr(3'd1, doutv);
         wr(3'd0, dirv);
         check("R2 pin_oe", pin_oe, dirv);
         check("R2 pin_out", pin_out, doutv);
         pin_in = pinv;
         idle(4);
         rd(3'd2, v);
         check("R3 data read", v, (doutv & dirv) | (pinv & ~dirv));
      end
      // R3: read latency of synchroniser, value visible four cycles on
      wr(3'd0, 32'h0);
      pin_in = 32'h0;
      idle(4);
      clear_all();
      pin_in = 32'h0000_0F00;
      idle(3);
      rd(3'd2, v);
      check("R3 sync latency", v, 32'h0000_0F00);
      pin_in = 32'h0;
      idle(4);
      clear_all();

      // R10: write to data word and unused word ignored
      wr(3'd0, 32'h0000_00FF);
      wr(3'd1, 32'h0000_0012);
      wr(3'd2, 32'hFFFF_FFFF);
      wr(3'd7, 32'hFFFF_FFFF);
      rd(3'd0, v);
      check("R10 dir after ignored write", v, 32'h0000_00FF);
      rd(3'd1, v);
      check("R10 dout after ignored write", v, 32'h0000_0012);
      rd(3'd7, v);
      check("R10 unused word", v, 32'h0);
      wr(3'd0, 32'h0);
      wr(3'd1, 32'h0);

      // R4 / R5 / R6: sweep every pin with a status slot, both polarities
      for (int pol = 1; pol >= 0; pol--) begin
         wr(3'd4, (pol == 1) ? 32'hFFFF_FFFF : 32'h0);
         for (int n = 0; n < 31; n++) begin
            pin_in[n] = 1'b1;
            idle(4);
            rd(3'd5, va);
            rd(3'd6, vd);
            check(pol == 1 ? "R4 rise assert" : "R5 rise assert", va,
                  pol == 1 ? (32'h1 << (n + 1)) : 32'h0);
            check(pol == 1 ? "R4 rise deassert" : "R5 rise deassert", vd,
                  pol == 1 ? 32'h0 : (32'h1 << (n + 1)));
            clear_all();
            pin_in[n] = 1'b0;
            idle(4);
            rd(3'd5, va);
            rd(3'd6, vd);
            check(pol == 1 ? "R4 fall assert" : "R5 fall assert", va,
                  pol == 1 ? 32'h0 : (32'h1 << (n + 1)));
            check(pol == 1 ? "R4 fall deassert" : "R5 fall deassert", vd,
                  pol == 1 ? (32'h1 << (n + 1)) : 32'h0);
            clear_all();
         end
      end

      // R6: pin 31 has no slot
      wr(3'd4, 32'hFFFF_FFFF);
      pin_in[31] = 1'b1;
      idle(4);
      pin_in[31] = 1'b0;
      idle(4);
      rd(3'd5, va);
      rd(3'd6, vd);
      check("R6 pin31 assert silent", va, 32'h0);
      check("R6 pin31 deassert silent", vd, 32'h0);

      // R7: write-one-to-clear, zeros keep bits
      pin_in[2] = 1'b1; pin_in[9] = 1'b1;
      idle(4);
      wr(3'd5, 32'h0);
      rd(3'd5, va);
      check("R7 zero write keeps", va, 32'h0000_0408);
      wr(3'd5, 32'h0000_0008);
      rd(3'd5, va);
      check("R7 partial clear", va, 32'h0000_0400);
      wr(3'd5, 32'h0000_0400);
      rd(3'd5, va);
      check("R7 full clear", va, 32'h0);
      pin_in[2] = 1'b0; pin_in[9] = 1'b0;
      idle(4);
      clear_all();

      // R8: event in the same cycle as its clear
      pin_in[3] = 1'b1;
      idle(4);
      pin_in[3] = 1'b0;
      idle(4);
      rd(3'd5, va);
      check("R8 setup assert set", va, 32'h0000_0010);
      @(negedge clk);
      pin_in[3] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'd5; bus_wdata = 32'h0000_0010;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      idle(2);
      rd(3'd5, va);
      check("R8 event beats clear", va, 32'h0000_0010);
      pin_in[3] = 1'b0;
      idle(4);
      clear_all();

      // R9: latch without enable, interrupt gating, separate lines
      pin_in[6] = 1'b1;
      idle(4);
      rd(3'd5, va);
      check("R9 latched without enable", va, 32'h0000_0080);
      check("R9 no irq without enable", {30'h0, irq_assert, irq_deassert}, 32'h0);
      clear_all();
      wr(3'd3, 32'h0000_0020);
      pin_in[5] = 1'b1;
      idle(4);
      check("R9 assert irq", {30'h0, irq_assert, irq_deassert}, 32'h2);
      pin_in[5] = 1'b0;
      idle(4);
      check("R9 both irqs", {30'h0, irq_assert, irq_deassert}, 32'h3);
      wr(3'd5, 32'h0000_0040);
      check("R9 deassert irq only", {30'h0, irq_assert, irq_deassert}, 32'h1);
      wr(3'd6, 32'h0000_0040);
      check("R9 irqs cleared", {30'h0, irq_assert, irq_deassert}, 32'h0);
      pin_in[6] = 1'b0;
      idle(4);
      clear_all();

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule